// File: doc/BRIEF.md
# Segment Base-Limit Translator

The block turns a two-part logical address into a linear address. A logical address is made of a segment selector and an offset inside that segment. The selector picks one entry of a small on-chip segment table. Each entry holds three things: a present flag, a base and a limit. When the offset is strictly below the limit, the result is base plus offset. When the offset is at or above the limit, or the entry is not present, the block raises a trap and produces no address.

Software or a controller loads the table through a write port, one entry per cycle. A requester drives one translation per cycle on the request port. The result appears one clock later on the output register, as either a grant or a fault with a cause code. Paging of the linear address is left to a later stage.

The result register is a three-state machine. `ST_IDLE` means no result. `ST_GRANT` means a legal translation. `ST_FAULT` means a trap. The next state is chosen on every clock:
- `GO_IDLE` is taken when no request is present.
- `GO_GRANT` is taken for a legal request.
- `GO_FAULT` is taken for an illegal request.

Any state can reach any other in one cycle.

Top module: `seg_xlate`

## Requirements
- R1: After reset, out_valid and out_trap are low, and every table entry is not present. A translation of any segment before its first write therefore faults with the absent cause.
- R2: With wr_en high at a clock edge, the entry selected by wr_seg takes wr_present, wr_base and wr_limit. Later translations of that segment use these values.
- R3: A legal request yields out_valid high and out_addr = base + offset, with the offset zero-extended and the sum wrapped modulo 2^32.
- R4: An offset equal to or greater than the entry limit faults with out_cause = 2'b01 (bounds). Offset limit-1 is still legal.
- R5: A request to an entry whose present flag is 0 faults with out_cause = 2'b10 (absent). The absent cause wins over the bounds cause.
- R6: Results appear exactly one cycle after the request edge. In a cycle after an edge with req_valid low, out_valid and out_trap are both low.
- R7: out_valid and out_trap are never high together. During a fault out_addr is 0. During a grant out_cause is 2'b00.
- R8: When a write and a translation hit the same segment at the same edge, the translation uses the entry's old contents. The next translation uses the new contents.
- R9: Writing one entry leaves every other entry unchanged.
- R10: The limit field is 17 bits wide. A limit of 0 makes every offset fault. A limit of 65536 makes offset 0xFFFF legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_seg | input | 3 | Segment selector of the request |
| req_off | input | 16 | Offset of the request |
| wr_en | input | 1 | Table write strobe |
| wr_seg | input | 3 | Entry to write |
| wr_present | input | 1 | Present flag to store |
| wr_base | input | 32 | Base to store |
| wr_limit | input | 17 | Limit to store (segment size) |
| out_valid | output | 1 | Registered grant flag |
| out_trap | output | 1 | Registered fault flag |
| out_cause | output | 2 | Fault cause: 00 none, 01 bounds, 10 absent |
| out_addr | output | 32 | Registered linear address, 0 unless granted |

## Verification
A table write and a translation can fall on the same clock edge, and the hazard is sharpest when both target the same segment. The bench drives wr_en and req_valid together at one edge, with new contents for the entry being translated. The result must reflect the old entry, which covers two cases: an old base, and an old absent flag that yields a fault. A follow-up request then has to see the new entry. The bench judges both results only from the output port, one cycle after each edge.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    // Fault cause encoding seen on out_cause.
    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_BOUNDS = 2'b01,
        CAUSE_ABSENT = 2'b10
    } cause_e;

    // State of the result register.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_GRANT = 2'b01,
        ST_FAULT = 2'b10
    } res_state_e;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
    parameter int SEGS   = 8,
    parameter int BASE_W = 32,
    parameter int LIM_W  = 17,
    localparam int IDX_W = $clog2(SEGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_present,
    input  logic [BASE_W-1:0] wr_base,
    input  logic [LIM_W-1:0]  wr_limit,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_present,
    output logic [BASE_W-1:0] rd_base,
    output logic [LIM_W-1:0]  rd_limit
);

    logic [SEGS-1:0]   present_q;
    logic [BASE_W-1:0] base_q  [SEGS];
    logic [LIM_W-1:0]  limit_q [SEGS];

    // One register set per entry; each loads only when it is addressed.
    for (genvar g = 0; g < SEGS; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                present_q[g] <= 1'b0;
                base_q[g]    <= '0;
                limit_q[g]   <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                present_q[g] <= wr_present;
                base_q[g]    <= wr_base;
                limit_q[g]   <= wr_limit;
            end
        end
    end

    // Read port reads the registers, so a same-edge write is not yet visible.
    always_comb begin
        rd_present = present_q[rd_idx];
        rd_base    = base_q[rd_idx];
        rd_limit   = limit_q[rd_idx];
    end

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int OFF_W  = 16,
    parameter int BASE_W = 32,
    localparam int LIM_W = OFF_W + 1
) (
    input  logic              present,
    input  logic [BASE_W-1:0] base,
    input  logic [LIM_W-1:0]  limit,
    input  logic [OFF_W-1:0]  offset,
    output logic              legal,
    output cause_e            cause,
    output logic [BASE_W-1:0] addr
);

    logic in_range;

    always_comb begin
        in_range = ({1'b0, offset} < limit);
        addr     = base + BASE_W'(offset);
        if (!present) begin
            legal = 1'b0;
            cause = CAUSE_ABSENT;
        end else if (!in_range) begin
            legal = 1'b0;
            cause = CAUSE_BOUNDS;
        end else begin
            legal = 1'b1;
            cause = CAUSE_NONE;
        end
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int SEGS   = 8,
    parameter int OFF_W  = 16,
    parameter int BASE_W = 32,
    localparam int IDX_W = $clog2(SEGS),
    localparam int LIM_W = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_seg,
    input  logic              wr_present,
    input  logic [BASE_W-1:0] wr_base,
    input  logic [LIM_W-1:0]  wr_limit,
    output logic              out_valid,
    output logic              out_trap,
    output logic [1:0]        out_cause,
    output logic [BASE_W-1:0] out_addr
);

    logic              ent_present;
    logic [BASE_W-1:0] ent_base;
    logic [LIM_W-1:0]  ent_limit;
    logic              chk_legal;
    cause_e            chk_cause;
    logic [BASE_W-1:0] chk_addr;

    res_state_e        state_q, state_d;
    cause_e            cause_q;
    logic [BASE_W-1:0] addr_q;

    seg_table #(
        .SEGS   (SEGS),
        .BASE_W (BASE_W),
        .LIM_W  (LIM_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_seg),
        .wr_present (wr_present),
        .wr_base    (wr_base),
        .wr_limit   (wr_limit),
        .rd_idx     (req_seg),
        .rd_present (ent_present),
        .rd_base    (ent_base),
        .rd_limit   (ent_limit)
    );

    seg_check #(
        .OFF_W  (OFF_W),
        .BASE_W (BASE_W)
    ) u_check (
        .present (ent_present),
        .base    (ent_base),
        .limit   (ent_limit),
        .offset  (req_off),
        .legal   (chk_legal),
        .cause   (chk_cause),
        .addr    (chk_addr)
    );

    // Transitions: GO_IDLE, GO_GRANT, GO_FAULT, reachable from every state.
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_GRANT, ST_FAULT: begin
                if (!req_valid)     state_d = ST_IDLE;
                else if (chk_legal) state_d = ST_GRANT;
                else                state_d = ST_FAULT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register plus the address and cause captured with it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cause_q <= CAUSE_NONE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            cause_q <= (state_d == ST_FAULT) ? chk_cause : CAUSE_NONE;
            addr_q  <= (state_d == ST_GRANT) ? chk_addr  : '0;
        end
    end

    // Output decode from the state.
    always_comb begin
        out_valid = 1'b0;
        out_trap  = 1'b0;
        out_cause = CAUSE_NONE;
        out_addr  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_GRANT: begin
                out_valid = 1'b1;
                out_addr  = addr_q;
            end
            ST_FAULT: begin
                out_trap  = 1'b1;
                out_cause = cause_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int BASE_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              out_valid,
    input logic              out_trap,
    input logic [1:0]        out_cause,
    input logic [BASE_W-1:0] out_addr
);

    assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_trap));

    assert_fault_no_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> (out_addr == '0) && (out_cause != 2'b00));

    assert_grant_no_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_cause == 2'b00));

    assert_idle_after_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && !out_trap));

    assert_answer_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (out_valid || out_trap));

    assert_cause_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_cause != 2'b11);

endmodule

bind seg_xlate seg_xlate_chk #(.BASE_W(BASE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .out_valid (out_valid),
    .out_trap  (out_trap),
    .out_cause (out_cause),
    .out_addr  (out_addr)
);

// File: tb/sim_seg_xlate.sv
`timescale 1ns/1ps
module sim_seg_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_seg = '0;
    logic [15:0] req_off = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_seg = '0;
    logic        wr_present = 1'b0;
    logic [31:0] wr_base = '0;
    logic [16:0] wr_limit = '0;
    logic        out_valid, out_trap;
    logic [1:0]  out_cause;
    logic [31:0] out_addr;

    int n_run = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    seg_xlate u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
        .wr_en(wr_en), .wr_seg(wr_seg), .wr_present(wr_present),
        .wr_base(wr_base), .wr_limit(wr_limit),
        .out_valid(out_valid), .out_trap(out_trap),
        .out_cause(out_cause), .out_addr(out_addr)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Table write alone: one edge.
    task automatic load(input logic [2:0] s, input bit p, input logic [31:0] b, input logic [16:0] l);
        @(negedge clk);
        wr_en = 1'b1; wr_seg = s; wr_present = p; wr_base = b; wr_limit = l;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Request at one edge, result checked at the following negedge.
    task automatic expect_grant(input logic [2:0] s, input logic [15:0] o, input logic [31:0] a, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_seg = s; req_off = o;
        @(negedge clk);
        req_valid = 1'b0;
        check(out_valid && !out_trap, {tag, " grant flags"}, {out_valid, out_trap}, 2'b10);
        check(out_addr == a, {tag, " address"}, out_addr, a);
    endtask

    task automatic expect_fault(input logic [2:0] s, input logic [15:0] o, input logic [1:0] c, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_seg = s; req_off = o;
        @(negedge clk);
        req_valid = 1'b0;
        check(!out_valid && out_trap, {tag, " fault flags"}, {out_valid, out_trap}, 2'b01);
        check(out_cause == c, {tag, " cause"}, out_cause, c);
        check(out_addr == 0, {tag, " fault address R7"}, out_addr, 0);
    endtask

    task automatic t_reset();
        check(!out_valid && !out_trap, "R1 reset flags", {out_valid, out_trap}, 0);
        expect_fault(3'd0, 16'd0, 2'b10, "R1 unwritten entry");
        expect_fault(3'd7, 16'd5, 2'b10, "R1 unwritten entry 7");
    endtask

    task automatic t_legal();
        load(3'd2, 1'b1, 32'd4300, 17'd400);
        expect_grant(3'd2, 16'd53, 32'd4353, "R2 R3 base plus offset");
        expect_grant(3'd2, 16'd0, 32'd4300, "R3 offset zero");
        load(3'd5, 1'b1, 32'hFFFF_FFF0, 17'd100);
        expect_grant(3'd5, 16'h20, 32'h10, "R3 wrap");
    endtask

    task automatic t_bounds();
        expect_grant(3'd2, 16'd399, 32'd4699, "R4 last legal offset");
        expect_fault(3'd2, 16'd400, 2'b01, "R4 offset equals limit");
        expect_fault(3'd2, 16'hFFFF, 2'b01, "R4 offset far beyond");
    endtask

    task automatic t_absent();
        load(3'd4, 1'b0, 32'd9000, 17'd10);
        expect_fault(3'd4, 16'd3, 2'b10, "R5 absent in range");
        expect_fault(3'd4, 16'd50, 2'b10, "R5 absent beats bounds");
    endtask

    task automatic t_idle();
        @(negedge clk);
        req_valid = 1'b1; req_seg = 3'd2; req_off = 16'd1;
        @(negedge clk);
        req_valid = 1'b0;
        check(out_valid, "R6 one cycle latency", out_valid, 1);
        @(negedge clk);
        check(!out_valid && !out_trap, "R6 idle after no request", {out_valid, out_trap}, 0);
    endtask

    task automatic t_collide();
        load(3'd1, 1'b1, 32'd100, 17'd10);
        @(negedge clk);
        wr_en = 1'b1; wr_seg = 3'd1; wr_present = 1'b1; wr_base = 32'd2000; wr_limit = 17'd10;
        req_valid = 1'b1; req_seg = 3'd1; req_off = 16'd5;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        check(out_valid && out_addr == 32'd105, "R8 old base on collision", out_addr, 105);
        expect_grant(3'd1, 16'd5, 32'd2005, "R8 new base after collision");
        // entry 3 is still absent; write it present on the same edge
        @(negedge clk);
        wr_en = 1'b1; wr_seg = 3'd3; wr_present = 1'b1; wr_base = 32'd50; wr_limit = 17'd10;
        req_valid = 1'b1; req_seg = 3'd3; req_off = 16'd1;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        check(out_trap && out_cause == 2'b10, "R8 old absent on collision", out_cause, 2);
        expect_grant(3'd3, 16'd1, 32'd51, "R8 new present entry");
    endtask

    task automatic t_isolate();
        expect_grant(3'd2, 16'd53, 32'd4353, "R9 entry 2 untouched");
        expect_grant(3'd5, 16'h20, 32'h10, "R9 entry 5 untouched");
    endtask

    task automatic t_limits();
        load(3'd7, 1'b1, 32'd777, 17'd0);
        expect_fault(3'd7, 16'd0, 2'b01, "R10 limit zero");
        load(3'd6, 1'b1, 32'h1000, 17'h10000);
        expect_grant(3'd6, 16'hFFFF, 32'h10FFF, "R10 full size segment");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_legal();
        t_bounds();
        t_absent();
        t_idle();
        t_collide();
        t_isolate();
        t_limits();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_bad++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

endmodule